// File: doc/BRIEF.md
# Shift-Add Four-Tap FIR Filter

This block is a four-tap finite impulse response filter whose coefficients are fixed at design time. It contains no multipliers. Each coefficient-times-sample product is broken into shifted copies of the sample, one for each set bit of the coefficient. A negative coefficient adds a single subtracted term for its sign bit. Two partial sums appear in more than one product. They are computed once, and the structure built on one of them is also computed once and reused.

The filter takes one signed sample per cycle when the sample-valid input is high. It keeps the three previous accepted samples in a short history. Each result is registered, and a valid flag marks it one cycle after the sample that produced it. The coefficients are 8-bit two's-complement values with one integer bit and seven fraction bits. The output is the integer sum of the coefficient codes times the samples, so the real value is that sum times 2^-7. By default the output has full precision. A parameter can drop a number of low bits, which gives a floor (truncating) result on a narrower port.

Top module: `fir4_shiftadd`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0 and out_data is 0. Reset also clears the sample history, so the first results after reset treat all older taps as zero.
- R2: For an accepted sample x0, with x1, x2 and x3 the three previously accepted samples (x1 the most recent), the result is 59*x3 + 43*x2 - 77*x1 - 54*x0. These are the coefficient codes 0.0111011, 0.0101011, 1.0110011 and 1.1001010 read as 8-bit two's complement.
- R3: No input sequence overflows the result, including samples at the most positive and most negative code. The output width is SAMPLE_W + 9 - DROP_LSB.
- R4: out_valid is 1 in exactly the cycle after each cycle with in_valid high, and 0 in every other cycle.
- R5: A sample presented with in_valid low does not enter the history and does not change any later result.
- R6: out_data holds its last value in every cycle that does not carry a new result.
- R7: With DROP_LSB greater than 0, out_data equals the full-precision result arithmetically shifted right by DROP_LSB, which rounds toward minus infinity.
- R8: Valid samples on consecutive cycles each produce a result on consecutive cycles. There are no stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_sample as a new sample |
| in_sample | input | SAMPLE_W | Signed two's-complement input sample |
| out_valid | output | 1 | High for one cycle when out_data carries a new result |
| out_data | output | SAMPLE_W+9-DROP_LSB | Signed filter result, registered |

## Verification
A wrong history slot appears at the ports as a result that is wrong one to three results later. The error shows when the stale or corrupted sample reaches the tap it feeds. An impulse test therefore gives a separate reading for every coefficient. A sample that leaks in while in_valid is low shifts every later tap. The results that follow it then disagree with the reference for at least three accepted samples. A wrong sign or shift in the shared sums shows at once in the result for that sample. At the most negative and most positive input codes, it also shows as a wrap of the output sign.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  // Four taps: the current sample plus three held ones.
  localparam int TAP_COUNT   = 4;
  localparam int HIST_DEPTH  = TAP_COUNT - 1;

  // Sum of coefficient magnitudes is 233 < 2^8, so growth of 8 bits plus
  // one bit of headroom for the intermediate terms of the shift-add network.
  localparam int GROWTH_BITS = 9;

  // Coefficient codes, 1 integer bit and 7 fraction bits, two's complement.
  // Only the checker reads these; the datapath encodes them as shifts.
  localparam logic [7:0] COEF_OLDEST  = 8'b0011_1011; //  59 on x3
  localparam logic [7:0] COEF_THIRD   = 8'b0010_1011; //  43 on x2
  localparam logic [7:0] COEF_SECOND  = 8'b1011_0011; // -77 on x1
  localparam logic [7:0] COEF_NEWEST  = 8'b1100_1010; // -54 on x0

endpackage

// File: rtl/fir4_tapline.sv
module fir4_tapline #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic signed [SAMPLE_W-1:0]   in_sample,
  output logic [DEPTH*SAMPLE_W-1:0]    hist_flat
);

  // Slot 0 holds the most recently accepted sample.
  logic signed [SAMPLE_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic signed [SAMPLE_W-1:0] feed;

    if (g == 0) begin : g_head
      assign feed = in_sample;
    end else begin : g_body
      assign feed = slot_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= '0;
      end else if (in_valid) begin
        slot_q[g] <= feed;
      end
    end

    assign hist_flat[g*SAMPLE_W +: SAMPLE_W] = slot_q[g];
  end

endmodule

// File: rtl/fir4_shared_terms.sv
module fir4_shared_terms #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 21
) (
  input  logic signed [SAMPLE_W-1:0] x0,
  input  logic signed [SAMPLE_W-1:0] x1,
  input  logic signed [SAMPLE_W-1:0] x2,
  input  logic signed [SAMPLE_W-1:0] x3,
  output logic signed [ACC_W-1:0]    sum13,
  output logic signed [ACC_W-1:0]    sum02,
  output logic signed [ACC_W-1:0]    sum13_x3
);

  logic signed [ACC_W-1:0] w0, w1, w2, w3;

  // Sign extension into the accumulator width.
  assign w0 = x0;
  assign w1 = x1;
  assign w2 = x2;
  assign w3 = x3;

  // Coefficients on x3 and x1 share bits 5,4,1,0 (weight 51).
  assign sum13    = w1 + w3;
  // Coefficients on x2 and x0 share bits 3,1 (weight 10).
  assign sum02    = w0 + w2;
  // 3*(x1+x3); 51 = 3 + 3*16, so this term serves both shared bit pairs.
  assign sum13_x3 = sum13 + (sum13 <<< 1);

endmodule

// File: rtl/fir4_combine.sv
module fir4_combine #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 21
) (
  input  logic signed [SAMPLE_W-1:0] x0,
  input  logic signed [SAMPLE_W-1:0] x1,
  input  logic signed [SAMPLE_W-1:0] x2,
  input  logic signed [SAMPLE_W-1:0] x3,
  input  logic signed [ACC_W-1:0]    sum02,
  input  logic signed [ACC_W-1:0]    sum13_x3,
  output logic signed [ACC_W-1:0]    total
);

  logic signed [ACC_W-1:0] w0, w1, w2, w3;
  logic signed [ACC_W-1:0] part13, part02, rest3, rest2, rest1, rest0;

  assign w0 = x0;
  assign w1 = x1;
  assign w2 = x2;
  assign w3 = x3;

  // Shared weight 51 on x1 and x3.
  assign part13 = sum13_x3 + (sum13_x3 <<< 4);
  // Shared weight 10 on x0 and x2.
  assign part02 = (sum02 <<< 3) + (sum02 <<< 1);

  // Leftover bits of each coefficient.
  assign rest3 = w3 <<< 3;               // 59 = 51 + 8
  assign rest2 = (w2 <<< 5) + w2;        // 43 = 10 + 33
  assign rest1 = w1 <<< 7;               // -77 = 51 - 128 (subtracted)
  assign rest0 = w0 <<< 6;               // -54 = 10 - 64  (subtracted)

  assign total = part13 + part02 + rest3 + rest2 - rest1 - rest0;

endmodule

// File: rtl/fir4_outreg.sv
module fir4_outreg #(
  parameter int ACC_W    = 21,
  parameter int DROP_LSB = 0,
  localparam int OUT_W   = ACC_W - DROP_LSB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [ACC_W-1:0] total,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  logic signed [OUT_W-1:0] narrowed;

  if (DROP_LSB == 0) begin : g_full
    assign narrowed = total;
  end else begin : g_trunc
    // Arithmetic shift gives floor division by 2^DROP_LSB.
    assign narrowed = OUT_W'(total >>> DROP_LSB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= narrowed;
      end
    end
  end

endmodule

// File: rtl/fir4_shiftadd.sv
module fir4_shiftadd
  import fir4_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DROP_LSB = 0
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              in_valid,
  input  logic signed [SAMPLE_W-1:0]                        in_sample,
  output logic                                              out_valid,
  output logic signed [SAMPLE_W+GROWTH_BITS-DROP_LSB-1:0]   out_data
);

  localparam int ACC_W = SAMPLE_W + GROWTH_BITS;

  logic [HIST_DEPTH*SAMPLE_W-1:0] hist_flat;
  logic signed [SAMPLE_W-1:0]     x1, x2, x3;
  logic signed [ACC_W-1:0]        sum13, sum02, sum13_x3, total;

  fir4_tapline #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (HIST_DEPTH)
  ) u_tapline (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .hist_flat (hist_flat)
  );

  assign x1 = hist_flat[0*SAMPLE_W +: SAMPLE_W];
  assign x2 = hist_flat[1*SAMPLE_W +: SAMPLE_W];
  assign x3 = hist_flat[2*SAMPLE_W +: SAMPLE_W];

  fir4_shared_terms #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_shared (
    .x0       (in_sample),
    .x1       (x1),
    .x2       (x2),
    .x3       (x3),
    .sum13    (sum13),
    .sum02    (sum02),
    .sum13_x3 (sum13_x3)
  );

  fir4_combine #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_combine (
    .x0       (in_sample),
    .x1       (x1),
    .x2       (x2),
    .x3       (x3),
    .sum02    (sum02),
    .sum13_x3 (sum13_x3),
    .total    (total)
  );

  fir4_outreg #(
    .ACC_W    (ACC_W),
    .DROP_LSB (DROP_LSB)
  ) u_outreg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .total     (total),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // sum13 feeds only the x3 stage inside the shared-term block; it is
  // exported for the checker's view of the network.
  logic sum13_seen;
  assign sum13_seen = ^sum13;

endmodule

// File: rtl/fir4_shiftadd_chk.sv
module fir4_shiftadd_chk
  import fir4_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DROP_LSB = 0,
  localparam int ACC_W   = SAMPLE_W + GROWTH_BITS,
  localparam int OUT_W   = ACC_W - DROP_LSB
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [SAMPLE_W-1:0] in_sample,
  input logic signed [SAMPLE_W-1:0] x1,
  input logic signed [SAMPLE_W-1:0] x2,
  input logic signed [SAMPLE_W-1:0] x3,
  input logic                    sum13_seen,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);

  localparam logic signed [ACC_W-1:0] K3 = ACC_W'($signed(COEF_OLDEST));
  localparam logic signed [ACC_W-1:0] K2 = ACC_W'($signed(COEF_THIRD));
  localparam logic signed [ACC_W-1:0] K1 = ACC_W'($signed(COEF_SECOND));
  localparam logic signed [ACC_W-1:0] K0 = ACC_W'($signed(COEF_NEWEST));

  logic signed [ACC_W-1:0] e0, e1, e2, e3, ref_full;
  logic signed [OUT_W-1:0] ref_out;

  assign e0 = in_sample;
  assign e1 = x1;
  assign e2 = x2;
  assign e3 = x3;
  // Reference by true multiplication, independent of the shift-add network.
  assign ref_full = K3 * e3 + K2 * e2 + K1 * e1 + K0 * e0;
  assign ref_out  = OUT_W'(ref_full >>> DROP_LSB);

  // R1: reset clears the output register.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R2, R3, R7: each result matches the multiplying reference.
  assert_exact_sum_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data == $past(ref_out)));

  // R4: valid flag follows the input flag by one cycle.
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R5: history moves only on accepted samples.
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(x1) && $stable(x2) && $stable(x3)));
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (x1 == $past(in_sample) && x2 == $past(x1) && x3 == $past(x2)));

  // R6: output data holds when no new result is produced.
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // Network probe must never be unknown once out of reset.
  assert_probe_known_R3: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sum13_seen));

endmodule

bind fir4_shiftadd fir4_shiftadd_chk #(
  .SAMPLE_W (SAMPLE_W),
  .DROP_LSB (DROP_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .x1         (x1),
  .x2         (x2),
  .x3         (x3),
  .sum13_seen (sum13_seen),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/test_fir4_shiftadd.sv
module test_fir4_shiftadd;

  localparam int CLK_PERIOD = 10;
  localparam int SW   = 12;
  localparam int DROP = 4;
  localparam int AW   = SW + 9;
  localparam int SMAX = (1 << (SW - 1)) - 1;
  localparam int SMIN = -(1 << (SW - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;

  logic                     out_valid, tr_valid;
  logic signed [AW-1:0]      out_data;
  logic signed [AW-DROP-1:0] tr_data;

  fir4_shiftadd #(.SAMPLE_W(SW), .DROP_LSB(0)) i_fir4_shiftadd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data));

  fir4_shiftadd #(.SAMPLE_W(SW), .DROP_LSB(DROP)) i_fir4_shiftadd_trunc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(tr_valid), .out_data(tr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int tag;
    int full;
    int req;
  } item_t;

  item_t q[$];
  int hist[3];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int last_full = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: pushes the expected result of each accepted sample (R2 formula).
  task automatic send(input bit v, input int s, input int req);
    @(negedge clk);
    in_valid  = v;
    in_sample = SW'(s);
    if (v) begin
      int full;
      full = 59*hist[2] + 43*hist[1] - 77*hist[0] - 54*s;
      q.push_back('{cyc, full, req});
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = s;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 3; i++) hist[i] = 0;
    last_full = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // Monitor: pops items in the cycle their result is due.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (q.size() > 0 && q[0].tag == cyc - 1) begin
          item_t it;
          it = q.pop_front();
          check(4, out_valid == 1'b1, int'(out_valid), 1);          // R4
          check(it.req, out_data == it.full, int'(out_data), it.full);
          check(7, tr_valid == 1'b1, int'(tr_valid), 1);            // R7
          check(7, tr_data == (it.full >>> DROP), int'(tr_data), it.full >>> DROP);
          last_full = it.full;
        end else begin
          check(4, out_valid == 1'b0, int'(out_valid), 0);          // R4
          check(6, out_data == last_full, int'(out_data), last_full); // R6
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports.
    check(1, out_valid == 1'b0, int'(out_valid), 0);
    check(1, out_data == 0, int'(out_data), 0);
    check(1, tr_data == 0, int'(tr_data), 0);
    rst = 1'b0;

    // R2: impulse reveals each coefficient on its own tap: -54, -77, 43, 59.
    send(1, 1, 2);
    send(1, 0, 2);
    send(1, 0, 2);
    send(1, 0, 2);
    send(0, 0, 6);
    send(1, -1, 2);
    repeat (3) send(1, 0, 2);
    repeat (2) send(0, 0, 6);

    // R5: junk presented without valid must not enter the history.
    for (int i = 0; i < 30; i++) begin
      send(1, int'($urandom_range(0, 4095)) - 2048, 5);
      send(0, (i % 2) ? SMAX : SMIN, 5);
      if (i % 3 == 0) send(0, 1234, 5);
    end

    // R8: back-to-back samples, one result per cycle.
    for (int i = 0; i < 40; i++) send(1, int'($urandom_range(0, 4095)) - 2048, 8);

    // R3: extremes for largest positive and negative sums.
    for (int i = 0; i < 3; i++) begin
      send(1, SMAX, 3); send(1, SMAX, 3); send(1, SMIN, 3); send(1, SMIN, 3);
    end
    for (int i = 0; i < 3; i++) begin
      send(1, SMIN, 3); send(1, SMIN, 3); send(1, SMAX, 3); send(1, SMAX, 3);
    end
    repeat (4) send(1, SMIN, 3);
    repeat (4) send(1, SMAX, 3);

    // R1: reset in the middle of a stream clears the history.
    repeat (3) send(0, 0, 6);
    @(negedge clk);
    rst = 1'b1;
    clear_model();
    repeat (2) @(negedge clk);
    check(1, out_valid == 1'b0, int'(out_valid), 0);
    check(1, out_data == 0, int'(out_data), 0);
    rst = 1'b0;
    send(1, 5, 1);
    send(1, 0, 1);
    send(1, 0, 1);
    send(1, 0, 1);

    // R6 and R5: random valid pattern with random data.
    for (int i = 0; i < 300; i++) begin
      send(($urandom_range(0, 2) != 0), int'($urandom_range(0, 4095)) - 2048, 6);
    end

    repeat (4) send(0, 0, 6);
    check(4, q.size() == 0, q.size(), 0);
    summary();
    $finish;
  end

endmodule